// File: doc/BRIEF.md
# Branch Source Trace Queue

This block is a debug history buffer that keeps the source addresses of recently taken branches. Each time the pipeline reports a branch while tracing is on, the low 28 bits of the branch instruction's address go into the front of an eight-slot shift queue with a valid flag, and the older entries move back one slot. Once the queue is full, the oldest entry falls off the end.

A debugger reads the history through one read-only 32-bit word. The word always shows the newest entry. A read strobe takes that entry off the queue, and the next-older entry moves forward to replace it. A reset at power-on clears every valid flag. So does a write that turns tracing on. The stored address bits are never reset, so they only have meaning when their flag is set.

Top module: `branch_trace_queue`

## Requirements
- R1: After power-on reset, tracing is off and every valid flag is 0. Eight successive reads all return bit 31 = 0.
- R2: While tracing is on, a cycle with `branchStrobe` high stores `branchAddr` into slot 0 with its valid flag set. Each older entry moves one slot further back.
- R3: The queue holds eight entries. After more than eight pushes, the reads return the eight newest addresses, newest first. The next read after those returns invalid.
- R4: `rdData` is the head entry at all times. Bit 31 is the valid flag, bits 30:28 are 0, and bits 27:0 are the stored address.
- R5: A cycle with `rdStrobe` high removes the head entry. The next-older entry becomes the head, and the vacated last slot becomes invalid.
- R6: A cycle with `traceEnWr` high and `traceEnVal` = 1 turns tracing on and clears every valid flag. It takes priority over a branch or a read in the same cycle.
- R7: Writing `traceEnVal` = 0 turns tracing off. Branches reported while tracing is off leave the queue unchanged.
- R8: A cycle with `wrStrobe` high and no other strobe leaves `rdData` unchanged.
- R9: When a read and a captured branch happen in the same cycle, `rdData` shows the old head during that cycle. The new address then becomes the head, and slots 1 to 7 keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| branchStrobe | input | 1 | A taken branch is reported this cycle |
| branchAddr | input | 28 | Bits 27:0 of the branch source address |
| traceEnWr | input | 1 | Write strobe for the trace-enable bit |
| traceEnVal | input | 1 | Value written to the trace-enable bit |
| rdStrobe | input | 1 | The bus reads the history word this cycle |
| wrStrobe | input | 1 | The bus writes the history word this cycle (ignored) |
| rdData | output | 32 | History word: head entry, formatted as in R4 |

## Verification
The bench goes after the corner cases where a shift in the wrong direction or a wrong priority would corrupt the history:
- Ten pushes overflow the queue. A design with an off-by-one depth would return a stale or missing ninth entry.
- A read and a branch in the same cycle check that the design replaces the head instead of losing an entry or duplicating one.
- A trace-enable write is issued together with a branch. A design with the wrong priority would leave one valid entry behind.
- Branches are sent while tracing is off, and a bus write is issued. Either one would show up as a changed read word if the design did not ignore it.

// File: rtl/btq_pkg.sv
package btq_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic clearAll;
  } btq_strobes_t;
endpackage

// File: rtl/btq_ctrl.sv
module btq_ctrl
  import btq_pkg::*;
(
  input  logic         clk,
  input  logic         porRstN,
  input  logic         branchStrobe,
  input  logic         traceEnWr,
  input  logic         traceEnVal,
  input  logic         rdStrobe,
  output btq_strobes_t stb
);
  logic traceOn;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)       traceOn <= 1'b0;
    else if (traceEnWr) traceOn <= traceEnVal;
  end

  always_comb begin
    stb.clearAll = traceEnWr & traceEnVal;
    stb.push     = branchStrobe & traceOn & ~stb.clearAll;
    stb.pop      = rdStrobe & ~stb.clearAll;
  end

  AST_OFF_NO_PUSH: assert property (@(posedge clk) disable iff (!porRstN)
    (traceEnWr && !traceEnVal) |=> !stb.push); // R7
  AST_ON_ALLOWS_PUSH: assert property (@(posedge clk) disable iff (!porRstN)
    (traceEnWr && traceEnVal) |=> (branchStrobe && !traceEnWr) == stb.push); // R2
endmodule

// File: rtl/btq_datapath.sv
module btq_datapath
  import btq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 28,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          porRstN,
  input  btq_strobes_t  stb,
  input  logic [AW-1:0] newAddr,
  output logic [DW-1:0] headWord
);
  localparam int PADW = DW - 1 - AW;

  logic [DEPTH-1:0] validQ;
  logic [AW-1:0]    addrQ  [DEPTH];
  logic [AW-1:0]    upSrc  [DEPTH];
  logic [AW-1:0]    downSrc[DEPTH];
  logic [DEPTH-1:0] upV;
  logic [DEPTH-1:0] downV;

  assign upV   = {validQ[DEPTH-2:0], 1'b1};
  assign downV = {1'b0, validQ[DEPTH-1:1]};

  for (genvar i = 0; i < DEPTH; i++) begin : g_src
    if (i == 0) begin : g_first
      assign upSrc[i] = newAddr;
    end else begin : g_rest
      assign upSrc[i] = addrQ[i-1];
    end
    if (i == DEPTH - 1) begin : g_last
      assign downSrc[i] = addrQ[i];
    end else begin : g_inner
      assign downSrc[i] = addrQ[i+1];
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                 validQ <= '0;
    else if (stb.clearAll)        validQ <= '0;
    else if (stb.push && stb.pop) validQ[0] <= 1'b1;
    else if (stb.push)            validQ <= upV;
    else if (stb.pop)             validQ <= downV;
  end

  always_ff @(posedge clk) begin
    if (!stb.clearAll) begin
      if (stb.push && stb.pop) addrQ[0] <= newAddr;
      else if (stb.push) begin
        for (int i = 0; i < DEPTH; i++) addrQ[i] <= upSrc[i];
      end else if (stb.pop) begin
        for (int i = 0; i < DEPTH; i++) addrQ[i] <= downSrc[i];
      end
    end
  end

  assign headWord = {validQ[0], {PADW{1'b0}}, addrQ[0]};

  AST_PUSH_HEAD: assert property (@(posedge clk) disable iff (!porRstN)
    stb.push |=> validQ[0] && addrQ[0] == $past(newAddr)); // R2
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!porRstN)
    stb.clearAll |=> validQ == '0); // R6
  AST_POP_SHIFT: assert property (@(posedge clk) disable iff (!porRstN)
    (stb.pop && !stb.push) |=> !validQ[DEPTH-1] && validQ[0] == $past(validQ[1])); // R5
  AST_SWAP_HOLD: assert property (@(posedge clk) disable iff (!porRstN)
    (stb.pop && stb.push) |=> validQ[DEPTH-1:1] == $past(validQ[DEPTH-1:1])); // R9
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!porRstN)
    (!stb.push && !stb.pop && !stb.clearAll) |=> $stable(validQ)); // R7
endmodule

// File: rtl/branch_trace_queue.sv
module branch_trace_queue
  import btq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 28,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          porRstN,
  input  logic          branchStrobe,
  input  logic [AW-1:0] branchAddr,
  input  logic          traceEnWr,
  input  logic          traceEnVal,
  input  logic          rdStrobe,
  input  logic          wrStrobe,
  output logic [DW-1:0] rdData
);
  btq_strobes_t stb;

  btq_ctrl u_ctrl (
    .clk          (clk),
    .porRstN      (porRstN),
    .branchStrobe (branchStrobe),
    .traceEnWr    (traceEnWr),
    .traceEnVal   (traceEnVal),
    .rdStrobe     (rdStrobe),
    .stb          (stb)
  );

  btq_datapath #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dp (
    .clk      (clk),
    .porRstN  (porRstN),
    .stb      (stb),
    .newAddr  (branchAddr),
    .headWord (rdData)
  );

  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!porRstN)
    (wrStrobe && !rdStrobe && !branchStrobe && !traceEnWr) |=> $stable(rdData)); // R8
endmodule

// File: tb/branch_trace_queue_test.sv
module branch_trace_queue_test;
  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        branchStrobe = 1'b0;
  logic [27:0] branchAddr = '0;
  logic        traceEnWr = 1'b0;
  logic        traceEnVal = 1'b0;
  logic        rdStrobe = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [31:0] rdData;

  int compared = 0;
  int mismatched = 0;

  // requirement-level model of the queue
  logic        mv [8];
  logic [27:0] ma [8];
  logic        mOn;

  always #2 clk = ~clk;

  branch_trace_queue uut (
    .clk(clk), .porRstN(porRstN), .branchStrobe(branchStrobe), .branchAddr(branchAddr),
    .traceEnWr(traceEnWr), .traceEnVal(traceEnVal), .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe), .rdData(rdData)
  );

  task automatic checkHead(input string tag);
    compared++;
    if (rdData[31] !== mv[0] || rdData[30:28] !== 3'b000 ||
        (mv[0] && rdData[27:0] !== ma[0])) begin
      mismatched++;
      $display("FAIL %s: rdData=%h expected valid=%0b addr=%h", tag, rdData, mv[0], ma[0]);
    end
  endtask

  // one clock cycle with the given strobes; checks head when reading
  task automatic cycle(input logic br, input logic [27:0] addr, input logic rd,
                       input logic ten, input logic tval, input logic wr, input string tag);
    logic push, pop, clr;
    branchStrobe = br; branchAddr = addr; rdStrobe = rd;
    traceEnWr = ten; traceEnVal = tval; wrStrobe = wr;
    #1;
    if (rd || wr) checkHead(tag);
    clr  = ten && tval;
    push = br && mOn && !clr;
    pop  = rd && !clr;
    if (clr) begin
      for (int i = 0; i < 8; i++) mv[i] = 1'b0;
    end else if (push && pop) begin
      mv[0] = 1'b1; ma[0] = addr;
    end else if (push) begin
      for (int i = 7; i > 0; i--) begin mv[i] = mv[i-1]; ma[i] = ma[i-1]; end
      mv[0] = 1'b1; ma[0] = addr;
    end else if (pop) begin
      for (int i = 0; i < 7; i++) begin mv[i] = mv[i+1]; ma[i] = ma[i+1]; end
      mv[7] = 1'b0;
    end
    if (ten) mOn = tval;
    @(posedge clk); #1;
    branchStrobe = 0; rdStrobe = 0; traceEnWr = 0; traceEnVal = 0; wrStrobe = 0;
  endtask

  task automatic branch(input logic [27:0] a); cycle(1, a, 0, 0, 0, 0, "R2"); endtask
  task automatic rd(input string tag);         cycle(0, '0, 1, 0, 0, 0, tag); endtask
  task automatic setTrace(input logic v);      cycle(0, '0, 0, 1, v, 0, "R6"); endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) rd("R1 reset read");
  endtask

  task automatic t_disabled;
    branch(28'h0AB_CDEF);
    rd("R7 branch while off");
  endtask

  task automatic t_fill;
    setTrace(1);
    branch(28'hFFF_FFFF); branch(28'h000_0001); branch(28'h123_4567);
    for (int i = 0; i < 4; i++) rd("R4 R5 fill/read");
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 10; i++) branch(28'h100_0000 + 28'(i * 16));
    for (int i = 0; i < 9; i++) rd("R3 overflow order");
  endtask

  task automatic t_enableClears;
    for (int i = 0; i < 4; i++) branch(28'h200_0000 + 28'(i));
    cycle(1, 28'h2FF_FFFF, 1, 1, 1, 0, "R6 clear priority");
    rd("R6 after clear");
    setTrace(0);
    branch(28'h333_3333);
    rd("R7 off after disable");
    setTrace(1);
  endtask

  task automatic t_readBranch;
    branch(28'hA00_000A); branch(28'hB00_000B);
    cycle(1, 28'hC00_000C, 1, 0, 0, 0, "R9 old head shown");
    for (int i = 0; i < 3; i++) rd("R9 after swap");
  endtask

  task automatic t_write;
    branch(28'h0DE_AD00);
    cycle(0, '0, 0, 0, 0, 1, "R8 before write");
    cycle(0, '0, 0, 0, 0, 1, "R8 after write");
    rd("R8 read after write");
  endtask

  initial begin
    #4000000;
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mv[i] = 1'b0; ma[i] = '0; end
    mOn = 1'b0;
    repeat (3) @(posedge clk);
    #1 porRstN = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_disabled();
    t_fill();
    t_overflow();
    t_enableClears();
    t_readBranch();
    t_write();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule